// File: doc/BRIEF.md
# APM Command and Status Port Pair

This block implements two byte-wide I/O registers that firmware and the operating system use to hand power-management control back and forth. A 1-bit select picks one of them: the command register (select 0) or the status register (select 1). Both registers accept byte writes, and both return their stored byte when read.

A write to the command register is also decoded as a command. Two code values switch the system into or out of ACPI mode. They do this by setting or clearing a level output that stands for the SCI-enable bit of the power-management control register. Every command write can also raise a system management interrupt request, which is a one-cycle pulse toward the CPU. The pulse is raised only when an enable bit supplied from the configuration space is set.

The status register is a plain scratch byte. Writing it has no side effects.

Top module: `apm_cmd_port`

## Requirements
- R1: After reset both stored bytes read 0x00, `sci_en_o` is 0 and `smi_o` is 0.
- R2: A write with `sel_i`=0 stores `wdata_i` in the command register. A read with `rd_i`=1 and `sel_i`=0 then returns that byte combinationally.
- R3: A write with `sel_i`=1 stores `wdata_i` in the status register, which reads back with `sel_i`=1. Such a write never changes `sci_en_o` and never pulses `smi_o`.
- R4: A command write of 0xF1 drives `sci_en_o` to 1 from the clock edge that takes the write.
- R5: A command write of 0xF0 drives `sci_en_o` to 0 from the clock edge that takes the write.
- R6: A command write of any other value is stored, but leaves `sci_en_o` unchanged.
- R7: A command write taken while `smi_cfg_en_i`=1 makes `smi_o` high for exactly the one cycle after that edge. A command write taken while `smi_cfg_en_i`=0 produces no pulse.
- R8: Command writes on consecutive cycles with the enable set give one pulse cycle per write, so `smi_o` stays high for as many cycles as there were writes.
- R9: While `rd_i`=0, `rdata_o` is 0x00.
- R10: A write to one register leaves the other register's stored byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Byte write strobe |
| rd_i | input | 1 | Byte read strobe |
| sel_i | input | 1 | Register select: 0 = command, 1 = status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when not reading |
| smi_cfg_en_i | input | 1 | Configuration bit that allows SMI requests |
| sci_en_o | output | 1 | SCI-enable (ACPI mode) level |
| smi_o | output | 1 | SMI request pulse |

## Verification
There are three kinds of internal fault, and each shows up at the ports within a predictable number of cycles:

- A corrupted SCI-enable flop shows on `sci_en_o` in the cycle after the offending write. It then persists until the next 0xF0 or 0xF1.
- A wrong pulse generator shows on `smi_o` in the single cycle after a command write, or as a missing or stretched pulse.
- A wrong stored byte is invisible until the register is read. For that reason the bench reads both registers back after every write.

The bench sweeps all 256 command values with the configuration enable both set and clear. Between the command writes it interleaves status writes, which checks that the registers are kept separate.

// File: rtl/apm_port_pkg.sv
package apm_port_pkg;
  localparam int DATA_W  = 8;
  localparam int N_PORTS = 2;
  typedef enum logic {
    PORT_CMD  = 1'b0,
    PORT_STAT = 1'b1
  } port_e;
endpackage

// File: rtl/apm_byte_reg.sv
module apm_byte_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/apm_sci_ctrl.sv
module apm_sci_ctrl #(
  parameter int           W       = 8,
  parameter logic [W-1:0] CODE_ON  = 8'hF1,
  parameter logic [W-1:0] CODE_OFF = 8'hF0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmd_we_i,
  input  logic [W-1:0] cmd_i,
  output logic         sci_en_o
);
  logic sci_d;

  always_comb begin
    sci_d = sci_en_o;
    if (cmd_we_i) begin
      if (cmd_i == CODE_ON)       sci_d = 1'b1;
      else if (cmd_i == CODE_OFF) sci_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sci_en_o <= 1'b0;
    else         sci_en_o <= sci_d;
  end
endmodule

// File: rtl/apm_smi_gen.sv
module apm_smi_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_we_i,
  input  logic cfg_en_i,
  output logic smi_o
);
  // one pulse cycle per qualifying write; back-to-back writes keep it high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smi_o <= 1'b0;
    else         smi_o <= cmd_we_i & cfg_en_i;
  end
endmodule

// File: rtl/apm_cmd_port.sv
module apm_cmd_port
  import apm_port_pkg::*;
#(
  parameter int                DW      = DATA_W,
  parameter logic [DW-1:0]     CODE_ON  = 8'hF1,
  parameter logic [DW-1:0]     CODE_OFF = 8'hF0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          smi_cfg_en_i,
  output logic          sci_en_o,
  output logic          smi_o
);
  logic [DW-1:0] port_q [N_PORTS];
  logic          cmd_we;

  assign cmd_we = wr_i && (sel_i == PORT_CMD);

  for (genvar i = 0; i < N_PORTS; i++) begin : g_port
    apm_byte_reg #(.W(DW)) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (wr_i && (sel_i == 1'(i))),
      .d_i   (wdata_i),
      .q_o   (port_q[i])
    );
  end

  apm_sci_ctrl #(.W(DW), .CODE_ON(CODE_ON), .CODE_OFF(CODE_OFF)) u_sci (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_we_i(cmd_we),
    .cmd_i   (wdata_i),
    .sci_en_o(sci_en_o)
  );

  apm_smi_gen u_smi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_we_i(cmd_we),
    .cfg_en_i(smi_cfg_en_i),
    .smi_o   (smi_o)
  );

  assign rdata_o = rd_i ? port_q[sel_i] : '0;
endmodule

// File: rtl/apm_cmd_port_chk.sv
module apm_cmd_port_chk #(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] CODE_ON  = 8'hF1,
  parameter logic [DW-1:0] CODE_OFF = 8'hF0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic          rd_i,
  input logic          sel_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          smi_cfg_en_i,
  input logic          sci_en_o,
  input logic          smi_o
);
  logic cmd_wr;
  assign cmd_wr = wr_i && !sel_i;

  AST_SCI_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && wdata_i == CODE_ON |=> sci_en_o); // R4
  AST_SCI_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && wdata_i == CODE_OFF |=> !sci_en_o); // R5
  AST_SCI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_wr && (wdata_i == CODE_ON || wdata_i == CODE_OFF)) |=> $stable(sci_en_o)); // R6
  AST_STAT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && sel_i |=> !smi_o && $stable(sci_en_o)); // R3
  AST_SMI_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && smi_cfg_en_i |=> smi_o); // R7
  AST_SMI_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_wr && smi_cfg_en_i) |=> !smi_o); // R8
  AST_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0); // R9
endmodule

bind apm_cmd_port apm_cmd_port_chk #(.DW(DW), .CODE_ON(CODE_ON), .CODE_OFF(CODE_OFF)) u_chk (.*);

// File: tb/tb_apm_cmd_port.sv
module tb_apm_cmd_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0, sel_i = 1'b0, smi_cfg_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       sci_en_o, smi_o;

  int checks = 0, errors = 0;
  logic       exp_sci = 1'b0;
  logic [7:0] exp_cmd = '0, exp_stat = '0;

  always #2 clk_i = ~clk_i;

  apm_cmd_port dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input logic s, input logic [7:0] exp, input string req);
    @(negedge clk_i);
    rd_i = 1'b1; sel_i = s;
    #1 chk(req, rdata_o, exp);
    rd_i = 1'b0;
    #0.5 chk("R9", rdata_o, 0);
  endtask

  // write one byte; sample outputs in the cycle following the write edge
  task automatic wr(input logic s, input logic [7:0] d, input logic cfg);
    @(negedge clk_i);
    wr_i = 1'b1; sel_i = s; wdata_i = d; smi_cfg_en_i = cfg;
    @(negedge clk_i);
    wr_i = 1'b0;
    if (!s) begin
      exp_cmd = d;
      if (d == 8'hF1) exp_sci = 1'b1;
      else if (d == 8'hF0) exp_sci = 1'b0;
      chk("R7", smi_o, cfg);
      chk(d == 8'hF1 ? "R4" : d == 8'hF0 ? "R5" : "R6", sci_en_o, exp_sci);
    end else begin
      exp_stat = d;
      chk("R3", smi_o, 0);
      chk("R3", sci_en_o, exp_sci);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1 chk("R1", sci_en_o, 0);
    chk("R1", smi_o, 0);
    #9 rst_ni = 1'b1;
    rd_chk(1'b0, 8'h00, "R1");
    rd_chk(1'b1, 8'h00, "R1");
    chk("R1", smi_o, 0);

    // directed ordering of set, hold, clear
    wr(1'b0, 8'hF1, 1'b0);
    wr(1'b0, 8'h55, 1'b1);
    chk("R6", sci_en_o, 1);
    wr(1'b1, 8'hF0, 1'b1);
    chk("R3", sci_en_o, 1);
    wr(1'b0, 8'hF0, 1'b1);
    wr(1'b0, 8'hAA, 1'b0);
    chk("R6", sci_en_o, 0);

    // full sweep of command values, enable set then clear, interleaved with status
    for (int pass = 0; pass < 2; pass++) begin
      for (int v = 0; v < 256; v++) begin
        wr(1'b0, 8'(v), pass == 0);
        rd_chk(1'b0, 8'(v), "R2");
        rd_chk(1'b1, exp_stat, "R10");
        wr(1'b1, ~8'(v), 1'b1);
        rd_chk(1'b1, ~8'(v), "R3");
        rd_chk(1'b0, 8'(v), "R10");
      end
    end

    // back-to-back qualifying writes: one pulse cycle per write
    @(negedge clk_i);
    wr_i = 1'b1; sel_i = 1'b0; smi_cfg_en_i = 1'b1; wdata_i = 8'hF1;
    @(negedge clk_i);
    chk("R8", smi_o, 1);
    wdata_i = 8'h33;
    @(negedge clk_i);
    chk("R8", smi_o, 1);
    wdata_i = 8'hF0;
    @(negedge clk_i);
    chk("R8", smi_o, 1);
    chk("R5", sci_en_o, 0);
    wr_i = 1'b0;
    @(negedge clk_i);
    chk("R8", smi_o, 0);
    rd_chk(1'b0, 8'hF0, "R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule